// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit launches a single command toward a card-side responder and collects what comes back. Software-facing logic presents an 11-bit command word together with a 32-bit argument and pulses a start strobe. The unit latches both values. One cycle later it raises a single-cycle request carrying the 6-bit command index and the argument. While waiting, it gathers response bytes one per clock.

The responder closes the exchange with an end marker. The marker carries the total response length and an optional error indication. The unit then judges the length against the expect-response and long-response control bits and raises exactly one of three sticky completion flags: command-sent, response-end or timeout.

On a good response the bytes are packed most significant byte first into four 32-bit words. Words 1 to 3 are zeroed for a 4-byte answer, and bit 0 of word 3 is zeroed for a 16-byte answer. Timeouts and commands without a response leave the stored words untouched. Serialisation onto the card lines and CRC handling sit outside this unit.

Top module: `cmd_resp_capture`

## Requirements
- R1: After reset, all three completion flags, `busy_o`, `cmd_enable_o` and `req_valid_o` are 0, and all four response words are zero.
- R2: When the unit is idle, a `start_i` pulse with command-word bit 10 (enable) set is accepted. The completion flags clear on the next edge, and `busy_o` and `cmd_enable_o` go high on that edge. `req_valid_o` is high for exactly the following cycle, with `req_index_o` equal to command-word bits 5:0 and `req_arg_o` equal to the argument.
- R3: A `start_i` pulse whose bit 10 is clear, or one that arrives while `busy_o` is high, produces no request and leaves the flags, `req_arg_o` and `busy_o` unchanged.
- R4: When command-word bit 6 (expect response) is clear and no error is reported, the end marker sets the command-sent flag and leaves the response words unchanged, whatever length is reported.
- R5: When bit 6 is set and the reported length is 4 with bit 7 (long response) clear, the response-end flag is set. Word 0 holds bytes 0 to 3 with byte 0 in bits 31:24, and words 1 to 3 are zero.
- R6: When bit 6 is set and the reported length is 16, the response-end flag is set whatever the value of bit 7. Word k holds bytes 4k to 4k+3, most significant first, and bit 0 of word 3 is forced to 0.
- R7: When bit 6 is set, a reported length of 0, a length of 4 with bit 7 set, or any length other than 4 or 16 sets the timeout flag and leaves the response words unchanged.
- R8: An end marker with `rsp_err_i` high sets the timeout flag whatever bits 6 and 7 hold.
- R9: Completion lowers `busy_o` and `cmd_enable_o` on the same edge that raises exactly one flag. The flag then holds until the next accepted start.
- R10: A response byte presented in the same cycle as the end marker is included in the captured words. Bytes beyond the sixteenth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe |
| cmd_word_i | input | 11 | Index in 5:0, expect response in 6, long response in 7, enable in 10 |
| cmd_arg_i | input | 32 | Command argument |
| req_valid_o | output | 1 | One-cycle request toward the responder |
| req_index_o | output | 6 | Latched command index |
| req_arg_o | output | 32 | Latched argument |
| rsp_valid_i | input | 1 | Response byte strobe |
| rsp_byte_i | input | 8 | Response byte |
| rsp_end_i | input | 1 | End-of-response marker |
| rsp_len_i | input | 5 | Total response length in bytes, valid with the marker |
| rsp_err_i | input | 1 | Responder error, valid with the marker |
| resp_word0_o | output | 32 | Response word 0 |
| resp_word1_o | output | 32 | Response word 1 |
| resp_word2_o | output | 32 | Response word 2 |
| resp_word3_o | output | 32 | Response word 3 |
| busy_o | output | 1 | Command in progress |
| cmd_enable_o | output | 1 | Enable bit readback, self-clearing on completion |
| flag_sent_o | output | 1 | Command sent without response |
| flag_resp_end_o | output | 1 | Response captured |
| flag_timeout_o | output | 1 | Response missing, malformed or failed |

## Verification
Two events can land on the same clock edge: storing the last response byte and closing the exchange on the end marker. The captured words must then already contain that final byte. Table rows with the same-cycle option drive the final byte and the marker together, for both 4-byte and 16-byte replies. In each such row the last byte sits in the least significant position of the final word, and the bench compares its predicted words against the outputs, including the forced-zero bit 0 of word 3.

// File: rtl/cmdcap_pkg.sv
package cmdcap_pkg;
    localparam int CMD_W     = 11;
    localparam int IDX_W     = 6;
    localparam int ARG_W     = 32;
    localparam int WORD_W    = 32;
    localparam int NWORD     = 4;
    localparam int BPW       = WORD_W / 8;
    localparam int NBYTE     = NWORD * BPW;
    localparam int BIDX_W    = $clog2(NBYTE);
    localparam int CNT_W     = $clog2(NBYTE + 1);
    localparam int LEN_W     = $clog2(NBYTE) + 1;
    localparam int SHORT_LEN = BPW;
    localparam int FULL_LEN  = NBYTE;

    // control bit positions within the command word
    localparam int CB_EXPECT = 6;
    localparam int CB_LONG   = 7;
    localparam int CB_EN     = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_SENT = 2'd1,
        OUT_REND = 2'd2,
        OUT_TMO  = 2'd3
    } verdict_e;
endpackage

// File: rtl/cmdcap_judge.sv
module cmdcap_judge
    import cmdcap_pkg::*;
(
    input  logic             expect_i,
    input  logic             long_i,
    input  logic             err_i,
    input  logic [LEN_W-1:0] len_i,
    output verdict_e         verdict_o,
    output logic             full_o
);
    logic is_short;
    logic is_full;

    always_comb begin
        is_short = (len_i == LEN_W'(SHORT_LEN));
        is_full  = (len_i == LEN_W'(FULL_LEN));
        full_o   = is_full;
        if (err_i) begin
            verdict_o = OUT_TMO;
        end else if (!expect_i) begin
            verdict_o = OUT_SENT;
        end else if (len_i == '0) begin
            verdict_o = OUT_TMO;
        end else if (is_short && long_i) begin
            verdict_o = OUT_TMO;
        end else if (!is_short && !is_full) begin
            verdict_o = OUT_TMO;
        end else begin
            verdict_o = OUT_REND;
        end
    end
endmodule

// File: rtl/cmdcap_ctrl.sv
module cmdcap_ctrl
    import cmdcap_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [ARG_W-1:0] arg_i,
    input  logic             done_i,
    input  verdict_e         verdict_i,
    output logic             req_valid_o,
    output logic             busy_o,
    output logic             en_o,
    output logic             wait_o,
    output logic             clear_o,
    output logic             capture_o,
    output logic             expect_o,
    output logic             long_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [ARG_W-1:0] arg_o,
    output logic             sent_o,
    output logic             rend_o,
    output logic             tmo_o
);
    typedef struct packed {
        ctl_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        logic             expect_r;
        logic             long_r;
        logic             en;
        logic             sent;
        logic             rend;
        logic             tmo;
    } ctl_t;

    ctl_t q, d;
    logic launch;
    logic finish;

    always_comb begin
        d      = q;
        launch = (q.st == ST_IDLE) && start_i && cmd_i[CB_EN];
        finish = (q.st == ST_WAIT) && done_i;
        unique case (q.st)
            ST_IDLE: begin
                if (launch) begin
                    d.st       = ST_ISSUE;
                    d.idx      = cmd_i[IDX_W-1:0];
                    d.arg      = arg_i;
                    d.expect_r = cmd_i[CB_EXPECT];
                    d.long_r   = cmd_i[CB_LONG];
                    d.en       = 1'b1;
                    d.sent     = 1'b0;
                    d.rend     = 1'b0;
                    d.tmo      = 1'b0;
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (finish) begin
                    d.st   = ST_IDLE;
                    d.en   = 1'b0;
                    d.sent = (verdict_i == OUT_SENT);
                    d.rend = (verdict_i == OUT_REND);
                    d.tmo  = (verdict_i == OUT_TMO);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_valid_o = (q.st == ST_ISSUE);
    assign busy_o      = (q.st != ST_IDLE);
    assign en_o        = q.en;
    assign wait_o      = (q.st == ST_WAIT);
    assign clear_o     = launch;
    assign capture_o   = finish && (verdict_i == OUT_REND);
    assign expect_o    = q.expect_r;
    assign long_o      = q.long_r;
    assign idx_o       = q.idx;
    assign arg_o       = q.arg;
    assign sent_o      = q.sent;
    assign rend_o      = q.rend;
    assign tmo_o       = q.tmo;
endmodule

// File: rtl/cmdcap_collect.sv
module cmdcap_collect
    import cmdcap_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clear_i,
    input  logic                         take_i,
    input  logic [7:0]                   byte_i,
    output logic [NWORD-1:0][WORD_W-1:0] word_nx_o
);
    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [NBYTE-1:0][7:0] bytes;
    } col_t;

    col_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d = '0;
        end else if (take_i && (q.cnt < CNT_W'(NBYTE))) begin
            d.bytes[q.cnt[BIDX_W-1:0]] = byte_i;
            d.cnt                      = q.cnt + CNT_W'(1);
        end
    end

    // big-endian packing from the next-state buffer, so a byte taken on
    // the closing edge is already visible to the result registers
    always_comb begin
        for (int k = 0; k < NWORD; k++) begin
            for (int j = 0; j < BPW; j++) begin
                word_nx_o[k][WORD_W-1-8*j -: 8] = d.bytes[k*BPW + j];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cmdcap_store.sv
module cmdcap_store
    import cmdcap_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         capture_i,
    input  logic                         full_i,
    input  logic [NWORD-1:0][WORD_W-1:0] word_nx_i,
    output logic [NWORD-1:0][WORD_W-1:0] words_o
);
    typedef struct packed {
        logic [NWORD-1:0][WORD_W-1:0] w;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (capture_i) begin
            for (int k = 0; k < NWORD; k++) begin
                if (k == 0 || full_i) begin
                    d.w[k] = word_nx_i[k];
                end else begin
                    d.w[k] = '0;
                end
            end
            if (full_i) begin
                d.w[NWORD-1][0] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign words_o = q.w;
endmodule

// File: rtl/cmd_resp_capture.sv
module cmd_resp_capture
    import cmdcap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    input  logic [ARG_W-1:0]  cmd_arg_i,
    output logic              req_valid_o,
    output logic [IDX_W-1:0]  req_index_o,
    output logic [ARG_W-1:0]  req_arg_o,
    input  logic              rsp_valid_i,
    input  logic [7:0]        rsp_byte_i,
    input  logic              rsp_end_i,
    input  logic [LEN_W-1:0]  rsp_len_i,
    input  logic              rsp_err_i,
    output logic [WORD_W-1:0] resp_word0_o,
    output logic [WORD_W-1:0] resp_word1_o,
    output logic [WORD_W-1:0] resp_word2_o,
    output logic [WORD_W-1:0] resp_word3_o,
    output logic              busy_o,
    output logic              cmd_enable_o,
    output logic              flag_sent_o,
    output logic              flag_resp_end_o,
    output logic              flag_timeout_o
);
    logic     launch;
    logic     waiting;
    logic     capture;
    logic     expect_s;
    logic     long_s;
    logic     full_s;
    verdict_e verdict;
    logic [NWORD-1:0][WORD_W-1:0] word_nx;
    logic [NWORD-1:0][WORD_W-1:0] words;

    cmdcap_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .cmd_i       (cmd_word_i),
        .arg_i       (cmd_arg_i),
        .done_i      (rsp_end_i),
        .verdict_i   (verdict),
        .req_valid_o (req_valid_o),
        .busy_o      (busy_o),
        .en_o        (cmd_enable_o),
        .wait_o      (waiting),
        .clear_o     (launch),
        .capture_o   (capture),
        .expect_o    (expect_s),
        .long_o      (long_s),
        .idx_o       (req_index_o),
        .arg_o       (req_arg_o),
        .sent_o      (flag_sent_o),
        .rend_o      (flag_resp_end_o),
        .tmo_o       (flag_timeout_o)
    );

    cmdcap_judge u_judge (
        .expect_i  (expect_s),
        .long_i    (long_s),
        .err_i     (rsp_err_i),
        .len_i     (rsp_len_i),
        .verdict_o (verdict),
        .full_o    (full_s)
    );

    cmdcap_collect u_collect (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (launch),
        .take_i    (waiting && rsp_valid_i),
        .byte_i    (rsp_byte_i),
        .word_nx_o (word_nx)
    );

    cmdcap_store u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .full_i    (full_s),
        .word_nx_i (word_nx),
        .words_o   (words)
    );

    assign resp_word0_o = words[0];
    assign resp_word1_o = words[1];
    assign resp_word2_o = words[2];
    assign resp_word3_o = words[3];
endmodule

// File: rtl/cmdcap_checker.sv
module cmdcap_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_valid_o,
    input logic        busy_o,
    input logic        cmd_enable_o,
    input logic        flag_sent_o,
    input logic        flag_resp_end_o,
    input logic        flag_timeout_o,
    input logic [31:0] resp_word0_o,
    input logic [31:0] resp_word1_o,
    input logic [31:0] resp_word2_o,
    input logic [31:0] resp_word3_o
);
    a_r9_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({flag_sent_o, flag_resp_end_o, flag_timeout_o}));

    a_r9_busy_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !(flag_sent_o || flag_resp_end_o || flag_timeout_o));

    a_r9_finish_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (flag_sent_o || flag_resp_end_o || flag_timeout_o));

    a_r2_enable_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_enable_o == busy_o);

    a_r2_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |=> !req_valid_o);

    a_r3_req_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> $rose(busy_o));

    a_r6_low_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_word3_o[0] == 1'b0);

    a_r7_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_timeout_o || flag_sent_o) |->
            $stable({resp_word0_o, resp_word1_o, resp_word2_o, resp_word3_o}));
endmodule

bind cmd_resp_capture cmdcap_checker u_checker (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_o     (req_valid_o),
    .busy_o          (busy_o),
    .cmd_enable_o    (cmd_enable_o),
    .flag_sent_o     (flag_sent_o),
    .flag_resp_end_o (flag_resp_end_o),
    .flag_timeout_o  (flag_timeout_o),
    .resp_word0_o    (resp_word0_o),
    .resp_word1_o    (resp_word1_o),
    .resp_word2_o    (resp_word2_o),
    .resp_word3_o    (resp_word3_o)
);

// File: tb/cmd_resp_capture_test.sv
module cmd_resp_capture_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [10:0] EN   = 11'h400;
    localparam logic [10:0] EXPR = 11'h040;
    localparam logic [10:0] LNG  = 11'h080;

    typedef struct packed {
        logic [10:0] cmd;
        logic [31:0] arg;
        logic [4:0]  nsend;
        logic [4:0]  len;
        logic        err;
        logic        same;
        logic [7:0]  seed;
        logic [1:0]  ex;     // 1 sent, 2 response end, 3 timeout
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{EN | 11'd0,               32'h0000_0000, 5'd0,  5'd0,  1'b0, 1'b0, 8'h00, 2'd1}, // R4
        '{EN | EXPR | 11'd17,       32'h1234_5678, 5'd4,  5'd4,  1'b0, 1'b0, 8'hA1, 2'd2}, // R5
        '{EN | EXPR | LNG | 11'd2,  32'hDEAD_BEEF, 5'd16, 5'd16, 1'b0, 1'b0, 8'h00, 2'd2}, // R6
        '{EN | EXPR | 11'd9,        32'h0000_0001, 5'd16, 5'd16, 1'b0, 1'b0, 8'h40, 2'd2}, // R6 short flag
        '{EN | EXPR | LNG | 11'd3,  32'h0000_0002, 5'd4,  5'd4,  1'b0, 1'b0, 8'h77, 2'd3}, // R7
        '{EN | EXPR | 11'd5,        32'h0000_0003, 5'd0,  5'd0,  1'b0, 1'b0, 8'h00, 2'd3}, // R7
        '{EN | EXPR | 11'd6,        32'h0000_0004, 5'd8,  5'd8,  1'b0, 1'b0, 8'h55, 2'd3}, // R7
        '{EN | 11'd7,               32'h0000_0005, 5'd0,  5'd0,  1'b1, 1'b0, 8'h00, 2'd3}, // R8
        '{EN | EXPR | 11'd13,       32'h0000_0006, 5'd4,  5'd4,  1'b1, 1'b0, 8'h99, 2'd3}, // R8
        '{EN | EXPR | LNG | 11'd63, 32'hCAFE_F00D, 5'd16, 5'd16, 1'b0, 1'b1, 8'h20, 2'd2}, // R10
        '{EN | 11'd1,               32'h0000_0007, 5'd4,  5'd4,  1'b0, 1'b0, 8'h3C, 2'd1}, // R4
        '{EN | EXPR | 11'd11,       32'h0000_0008, 5'd4,  5'd31, 1'b0, 1'b0, 8'h11, 2'd3}, // R7
        '{EN | EXPR | 11'd12,       32'h0BAD_CAFE, 5'd4,  5'd4,  1'b0, 1'b1, 8'hE0, 2'd2}, // R10
        '{EN | EXPR | LNG | 11'd40, 32'h0000_0009, 5'd18, 5'd16, 1'b0, 1'b0, 8'h60, 2'd2}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] cmd = '0;
    logic [31:0] arg = '0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = '0;
    logic        rsp_end = 1'b0;
    logic [4:0]  rsp_len = '0;
    logic        rsp_err = 1'b0;
    logic        req_valid;
    logic [5:0]  req_index;
    logic [31:0] req_arg;
    logic [31:0] w0, w1, w2, w3;
    logic        busy, cmd_en, f_sent, f_rend, f_tmo;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_w [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_resp_capture uut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .start_i         (start),
        .cmd_word_i      (cmd),
        .cmd_arg_i       (arg),
        .req_valid_o     (req_valid),
        .req_index_o     (req_index),
        .req_arg_o       (req_arg),
        .rsp_valid_i     (rsp_valid),
        .rsp_byte_i      (rsp_byte),
        .rsp_end_i       (rsp_end),
        .rsp_len_i       (rsp_len),
        .rsp_err_i       (rsp_err),
        .resp_word0_o    (w0),
        .resp_word1_o    (w1),
        .resp_word2_o    (w2),
        .resp_word3_o    (w3),
        .busy_o          (busy),
        .cmd_enable_o    (cmd_en),
        .flag_sent_o     (f_sent),
        .flag_resp_end_o (f_rend),
        .flag_timeout_o  (f_tmo)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input logic [7:0] s, input int i);
        return s + 8'(i * 19);
    endfunction

    function automatic logic [31:0] pack(input logic [7:0] s, input int k);
        return {bval(s, 4*k), bval(s, 4*k+1), bval(s, 4*k+2), bval(s, 4*k+3)};
    endfunction

    function automatic logic [2:0] flag_code(input logic [1:0] ex);
        case (ex)
            2'd1:    return 3'b100;
            2'd2:    return 3'b010;
            2'd3:    return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check_words(input string req);
        chk(req, {w0, w1, w2, w3}, {exp_w[0], exp_w[1], exp_w[2], exp_w[3]});
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        start = 1'b1; cmd = v.cmd; arg = v.arg;
        @(negedge clk);
        start = 1'b0;
        chk("R2 request pulse", req_valid, 1'b1);
        chk("R2 index", req_index, v.cmd[5:0]);
        chk("R2 argument", req_arg, v.arg);
        chk("R2 busy and enable", {busy, cmd_en}, 2'b11);
        chk("R2 flags cleared", {f_sent, f_rend, f_tmo}, 3'b000);
        @(negedge clk);
        chk("R2 single request", req_valid, 1'b0);
        for (int i = 0; i < int'(v.nsend); i++) begin
            rsp_valid = 1'b1;
            rsp_byte  = bval(v.seed, i);
            if (v.same && i == int'(v.nsend) - 1) begin
                rsp_end = 1'b1; rsp_len = v.len; rsp_err = v.err;
            end
            @(negedge clk);
            rsp_end = 1'b0; rsp_err = 1'b0;
        end
        rsp_valid = 1'b0;
        if (!(v.same && v.nsend != 0)) begin
            rsp_end = 1'b1; rsp_len = v.len; rsp_err = v.err;
            @(negedge clk);
            rsp_end = 1'b0; rsp_err = 1'b0;
        end
        if (v.ex == 2'd2) begin
            for (int k = 0; k < 4; k++) exp_w[k] = pack(v.seed, k);
            if (v.len == 5'd4) begin
                exp_w[1] = '0; exp_w[2] = '0; exp_w[3] = '0;
            end else begin
                exp_w[3][0] = 1'b0;
            end
        end
        chk("R9 outcome flags R4 R5 R6 R7 R8", {f_sent, f_rend, f_tmo}, flag_code(v.ex));
        chk("R9 busy and enable dropped", {busy, cmd_en}, 2'b00);
        check_words("R5 R6 R7 R10 response words");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) exp_w[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {f_sent, f_rend, f_tmo}, 3'b000);
        chk("R1 busy enable request", {busy, cmd_en, req_valid}, 3'b000);
        check_words("R1 words");

        for (int n = 0; n < NV; n++) run_vec(TBL[n]);

        // R3: start with enable clear is ignored
        begin
            logic [2:0] fl;
            logic [31:0] a;
            fl = {f_sent, f_rend, f_tmo};
            a  = req_arg;
            @(negedge clk);
            start = 1'b1; cmd = EXPR | 11'd22; arg = 32'h5555_AAAA;
            @(negedge clk);
            start = 1'b0;
            chk("R3 no request without enable", {req_valid, busy}, 2'b00);
            chk("R3 flags kept", {f_sent, f_rend, f_tmo}, fl);
            chk("R3 argument kept", req_arg, a);
        end

        // R3: start while busy is ignored
        @(negedge clk);
        start = 1'b1; cmd = EN | EXPR | 11'd30; arg = 32'hAAAA_0001;
        @(negedge clk);
        start = 1'b0;
        chk("R3 first request", req_valid, 1'b1);
        @(negedge clk);
        start = 1'b1; cmd = EN | 11'd31; arg = 32'hBBBB_0002;
        @(negedge clk);
        start = 1'b0;
        chk("R3 no request while busy", req_valid, 1'b0);
        chk("R3 argument held while busy", req_arg, 32'hAAAA_0001);
        chk("R3 index held while busy", req_index, 6'd30);
        for (int i = 0; i < 4; i++) begin
            rsp_valid = 1'b1; rsp_byte = bval(8'h0F, i);
            @(negedge clk);
        end
        rsp_valid = 1'b0; rsp_end = 1'b1; rsp_len = 5'd4;
        @(negedge clk);
        rsp_end = 1'b0;
        exp_w[0] = pack(8'h0F, 0); exp_w[1] = '0; exp_w[2] = '0; exp_w[3] = '0;
        chk("R3 R5 command completes", {f_sent, f_rend, f_tmo, busy}, 4'b0100);
        check_words("R5 words after busy start");
        repeat (3) @(negedge clk);
        chk("R9 flag holds in idle", {f_sent, f_rend, f_tmo}, 3'b010);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule